// File: doc/BRIEF.md
# Dual Event Counter Peripheral

This peripheral sits on the nibble-wide data bus of a small microcontroller and counts pulses that arrive on two external event lines. It holds two 8-bit counters. Software reads each counter as two 4-bit halves at neighbouring addresses, and it steers the block through one control nibble. That nibble selects the counting mode and the run/stop state, and it carries one write-one clear strobe per counter.

Each event line first passes through a two-flop synchroniser. A rising-edge detector follows it. In separate mode, each counter counts the rising edges of its own line. In phase mode, the two lines are read as a two-phase pair. A rising edge on one line counts only while the other line is low. This lets software tell which line leads.

The bus has no back-pressure. A write takes effect on the clock edge where `wr_en` is high. Read data is combinational from `addr` while `rd_en` is high, and is 0 at all other times. Ports that carry no data flow stay plain.

Top module: `evc_dual_counter`

## Requirements
- R1: After reset both counters hold 0x00, the run bit is 0 (stopped) and the mode bit is 0 (separate), so every mapped address reads 0.
- R2: While `rd_en` is high, `rdata` shows the nibble selected by `addr`. Offset 0x8 gives counter 0 bits 3:0, 0x9 gives counter 0 bits 7:4, 0xA gives counter 1 bits 3:0 and 0xB gives counter 1 bits 7:4. Offset 0xC gives {mode, run, 0, 0}. Any other offset reads 0, and `rdata` is 0 while `rd_en` is low.
- R3: Writes to offsets 0x8 to 0xB have no effect on either counter.
- R4: A write to 0xC with bit 0 set clears counter 0 to 0x00, and bit 1 set clears counter 1 to 0x00. A 0 in either bit leaves that counter unchanged. Both strobe bits read back as 0.
- R5: In separate mode (bit 3 = 0) with run = 1, each counter adds one per rising edge of its own event input. The count wraps from 0xFF to 0x00.
- R6: With run (bit 2 of 0xC) at 0, neither counter changes, whatever the event inputs do.
- R7: In phase mode (bit 3 = 1) with run = 1, a rising edge on input 0 adds one to counter 0 only while input 1 is low. A rising edge on input 1 adds one to counter 1 only while input 0 is low. Other edges do not count, and the two counters never step in the same cycle.
- R8: When a clear strobe and a counting edge reach the same counter on the same clock edge, the clear wins and the counter ends at 0x00.
- R9: An event input edge is seen through two synchroniser flops. A single level change counts exactly once, and the count becomes visible no later than the third clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| event_in | input | 2 | Asynchronous event lines, bit i feeds counter i |
| addr | input | 4 | Nibble register offset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe |
| wdata | input | 4 | Write data nibble |
| rdata | output | 4 | Read data nibble |

## Verification
Two things can hit the same counter on one clock edge: a software clear strobe and a synchronised counting edge. The bench gets a counter to a nonzero value first. It then raises that counter's event line and waits two clock edges, so the detected edge is live in the next cycle. It issues the clear write in exactly that cycle. A final value of 0x00 shows that the clear won. A value one above the old count, or 0x01, shows that the increment leaked through.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int unsigned NIB_W = 4;

  typedef enum logic {
    MODE_SEPARATE = 1'b0,
    MODE_PHASE    = 1'b1
  } evc_mode_e;
endpackage

// File: rtl/evc_edge_sync.sv
module evc_edge_sync #(
  parameter int unsigned LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] async_in,
  output logic [LANES-1:0] level,
  output logic [LANES-1:0] rise
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic meta_q, sync_q, last_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        last_q <= 1'b0;
      end else begin
        meta_q <= async_in[i];
        sync_q <= meta_q;
        last_q <= sync_q;
      end
    end

    assign level[i] = sync_q;
    assign rise[i]  = sync_q & ~last_q;

    AST_EDGE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      rise[i] |=> !rise[i]) else $error("edge held two cycles"); // R9
  end
endmodule

// File: rtl/evc_counter.sv
module evc_counter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [WIDTH-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= count + 1'b1;
  end

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0) else $error("clear lost"); // R8

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |=> count == WIDTH'($past(count) + 1'b1)) else $error("bad step"); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> $stable(count)) else $error("count drifted"); // R6
endmodule

// File: rtl/evc_dual_counter.sv
module evc_dual_counter
  import evc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter logic [3:0]  OFS_C0_LO = 4'h8,
  parameter logic [3:0]  OFS_C0_HI = 4'h9,
  parameter logic [3:0]  OFS_C1_LO = 4'hA,
  parameter logic [3:0]  OFS_C1_HI = 4'hB,
  parameter logic [3:0]  OFS_CTRL  = 4'hC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        event_in,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [NIB_W-1:0]  wdata,
  output logic [NIB_W-1:0]  rdata
);
  localparam int unsigned LANES = 2;
  localparam int unsigned CNT_W = 2 * NIB_W;

  logic [LANES-1:0] lvl, rise, inc, clr;
  logic [CNT_W-1:0] cnt [LANES];
  logic             run_q;
  evc_mode_e        mode_q;
  logic             ctrl_wr;

  evc_edge_sync #(.LANES(LANES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(event_in), .level(lvl), .rise(rise)
  );

  assign ctrl_wr = wr_en && (addr == ADDR_W'(OFS_CTRL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      mode_q <= MODE_SEPARATE;
    end else if (ctrl_wr) begin
      run_q  <= wdata[2];
      mode_q <= evc_mode_e'(wdata[3]);
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_cnt
    localparam int unsigned OTHER = LANES - 1 - i;

    assign clr[i] = ctrl_wr && wdata[i];

    always_comb begin
      if (!run_q)                    inc[i] = 1'b0;
      else if (mode_q == MODE_PHASE) inc[i] = rise[i] & ~lvl[OTHER];
      else                           inc[i] = rise[i];
    end

    evc_counter #(.WIDTH(CNT_W)) u_counter (
      .clk(clk), .rst_n(rst_n), .clr(clr[i]), .inc(inc[i]), .count(cnt[i])
    );
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (addr)
        ADDR_W'(OFS_C0_LO): rdata = cnt[0][NIB_W-1:0];
        ADDR_W'(OFS_C0_HI): rdata = cnt[0][CNT_W-1:NIB_W];
        ADDR_W'(OFS_C1_LO): rdata = cnt[1][NIB_W-1:0];
        ADDR_W'(OFS_C1_HI): rdata = cnt[1][CNT_W-1:NIB_W];
        ADDR_W'(OFS_CTRL):  rdata = {mode_q, run_q, 2'b00};
        default:            rdata = '0;
      endcase
    end
  end

  AST_STOPPED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !ctrl_wr) |=> ($stable(cnt[0]) && $stable(cnt[1])))
    else $error("counter moved while stopped"); // R6

  AST_PHASE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_PHASE) |-> $onehot0(inc))
    else $error("both phases stepped"); // R7

  AST_DATA_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ctrl_wr && !(|rise)) |=> ($stable(cnt[0]) && $stable(cnt[1])))
    else $error("data write changed a counter"); // R3
endmodule

// File: tb/test_evc_dual_counter.sv
module test_evc_dual_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] event_in = '0;
  logic [3:0] addr = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [3:0] wdata = '0;
  logic [3:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [3:0] exp_q [$];
  string      tag_q [$];

  always #10 clk = ~clk;

  evc_dual_counter i_evc_dual_counter (
    .clk(clk), .rst_n(rst_n), .event_in(event_in), .addr(addr),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata)
  );

  // monitor: samples mid low phase, pops expected items
  always begin
    @(negedge clk);
    #5;
    if (rd_en) begin
      logic [3:0] e;
      string t;
      if (exp_q.size() == 0) begin
        errors++; checks++;
        $display("FAIL scoreboard empty: actual=%h expected=none", rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s addr=%h: actual=%h expected=%h", t, addr, rdata, e);
        end
      end
    end else if (rdata !== 4'h0) begin
      checks++; errors++;
      $display("FAIL R2 idle bus: actual=%h expected=0", rdata);
    end
  end

  task automatic bus_wr(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, input logic [3:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk_cnt(input int which, input logic [7:0] e, input string t);
    logic [3:0] base;
    base = (which == 0) ? 4'h8 : 4'hA;
    bus_rd(base, e[3:0], t);
    bus_rd(base + 4'h1, e[7:4], t);
  endtask

  task automatic pulse(input int idx, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); event_in[idx] = 1'b1;
      repeat (3) @(negedge clk);
      event_in[idx] = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_cnt(0, 8'h00, "R1");
    chk_cnt(1, 8'h00, "R1");
    bus_rd(4'hC, 4'h0, "R1");

    // R6 stopped: pulses ignored
    pulse(0, 3); pulse(1, 2);
    chk_cnt(0, 8'h00, "R6");
    chk_cnt(1, 8'h00, "R6");

    // R5 separate mode run; R9 single count per edge
    bus_wr(4'hC, 4'b0100);
    bus_rd(4'hC, 4'b0100, "R4");
    pulse(0, 5); pulse(1, 3);
    chk_cnt(0, 8'h05, "R5");
    chk_cnt(1, 8'h03, "R9");

    // R9 visible by third edge after change
    @(negedge clk); event_in[0] = 1'b1;
    repeat (3) @(negedge clk);
    chk_cnt(0, 8'h06, "R9");
    event_in[0] = 1'b0;
    repeat (3) @(negedge clk);

    // R2 unmapped and other offsets
    bus_rd(4'h0, 4'h0, "R2");
    bus_rd(4'hD, 4'h0, "R2");
    bus_rd(4'h7, 4'h0, "R2");

    // R3 writes to data offsets ignored
    bus_wr(4'h8, 4'hF); bus_wr(4'h9, 4'hF);
    bus_wr(4'hA, 4'hF); bus_wr(4'hB, 4'hF);
    chk_cnt(0, 8'h06, "R3");
    chk_cnt(1, 8'h03, "R3");

    // R4 zero strobes do nothing, then selective clear
    bus_wr(4'hC, 4'b0100);
    chk_cnt(0, 8'h06, "R4");
    bus_wr(4'hC, 4'b0110);
    chk_cnt(0, 8'h06, "R4");
    chk_cnt(1, 8'h00, "R4");
    bus_rd(4'hC, 4'b0100, "R4");

    // R6 stop freezes after counting
    bus_wr(4'hC, 4'b0000);
    pulse(0, 2);
    chk_cnt(0, 8'h06, "R6");
    bus_wr(4'hC, 4'b0100);

    // R8 clear and counting edge on the same clock edge
    @(negedge clk); event_in[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    addr = 4'hC; wdata = 4'b0101; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    repeat (2) @(negedge clk);
    event_in[0] = 1'b0;
    repeat (3) @(negedge clk);
    chk_cnt(0, 8'h00, "R8");

    // R5 wrap on counter 1
    bus_wr(4'hC, 4'b0110);
    pulse(1, 255);
    chk_cnt(1, 8'hFF, "R5");
    pulse(1, 1);
    chk_cnt(1, 8'h00, "R5");

    // R7 phase mode
    bus_wr(4'hC, 4'b1111);
    bus_rd(4'hC, 4'b1100, "R7");
    @(negedge clk); event_in[1] = 1'b1;
    repeat (4) @(negedge clk);
    pulse(0, 2);
    chk_cnt(0, 8'h00, "R7");
    chk_cnt(1, 8'h01, "R7");
    @(negedge clk); event_in[1] = 1'b0;
    repeat (4) @(negedge clk);
    pulse(0, 3);
    chk_cnt(0, 8'h03, "R7");
    @(negedge clk); event_in[0] = 1'b1;
    repeat (4) @(negedge clk);
    pulse(1, 2);
    event_in[0] = 1'b0;
    repeat (4) @(negedge clk);
    chk_cnt(0, 8'h04, "R7");
    chk_cnt(1, 8'h01, "R7");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++; checks++;
      $display("FAIL scoreboard leftover: actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule